// File: doc/BRIEF.md
# Vertical-Referenced Video Line Gate

This block opens a gate for one chosen video line, or for a run of adjacent lines, once in every field or frame. It watches a digitised composite sync waveform and a start reference. The start reference is either the vertical pulse or a field index. On the falling edge of the reference it loads a down counter with the requested line number plus two and arms itself. It then counts every sync transition, rising or falling, until the counter runs out, and at that point the gate opens.

The gate output is meant to drive an external analog switch that passes the selected video. Its complement enables an external black-level clamp while no selected line is being passed.

The counter counts transitions rather than lines. Through the half-line region of the vertical interval there are two transitions for each half line, so a selected line of 14 lines up with the 16th transition after the reference edge. Both sync and reference go through an edge-detect pipeline. Every input event therefore takes effect two clock cycles after it appears at the pins.

Top module: `video_line_gate`

## Requirements
- R1: While rst_n is low and after it is released, line_gate is 0 and clamp_en is 1. The block is disarmed with both counters at zero.
- R2: Transitions on csync do not open the gate when no reference falling edge has occurred since reset, or since the last run closed.
- R3: A reference falling edge arms the block and loads line_sel + 2. Each csync transition in either direction then counts one while the block is armed and the gate is closed. line_gate rises two clock cycles after the (line_sel + 2)-th transition appears at csync, so line_sel = 14 opens on the 16th transition.
- R4: csync is high during a sync pulse, and a line boundary is a rising edge of csync. Once the gate is open, line_gate falls two cycles after the run_len-th rising edge of csync, and run_len = 0 acts as 1. Closing disarms the block, and further transitions do not reopen the gate. line_sel and run_len are sampled at the reference edge.
- R5: With field_mode = 0 the reference is vpulse, and field_idx is ignored. With field_mode = 1 the reference is field_idx XOR field_inv, and vpulse is ignored. With field_inv = 1, a rising edge of field_idx starts the count.
- R6: A reference falling edge that arrives while counting, or while the gate is open, reloads the counter and restarts the count. The gate closes two cycles after that reference edge.
- R7: clamp_en is always the complement of line_gate.
- R8: line_sel accepts values up to 2046. line_sel = 2046 opens the gate on the 2048th transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csync | input | 1 | Composite sync, high during sync pulses |
| vpulse | input | 1 | Vertical pulse; its falling edge is the reference when field_mode = 0 |
| field_idx | input | 1 | Field index level |
| field_mode | input | 1 | 0: reference is vpulse; 1: reference is field_idx XOR field_inv |
| field_inv | input | 1 | Inverts field_idx in field mode |
| line_sel | input | 11 | Selected line number |
| run_len | input | 8 | Number of adjacent lines to pass (0 acts as 1) |
| line_gate | output | 1 | High while selected lines are passed |
| clamp_en | output | 1 | Black-level clamp enable, high while the gate is closed |

## Verification
The assertions assume that successive events on csync and on the selected reference are at least two clock cycles apart. Under that assumption each detected edge is acted on before the next one appears. They also assume that the counters never wrap, because the block only counts down from a value of one or more.

The stimulus spaces every csync toggle three cycles apart and holds each reference level for three cycles. It never lets a reference edge coincide with a sync edge. Mode and inversion inputs are only changed when the change produces a rising reference edge, or a falling edge that the bench deliberately uses as a start.

// File: rtl/vlg_pkg.sv
package vlg_pkg;
   typedef enum logic {
      REF_VERT  = 1'b0,
      REF_FIELD = 1'b1
   } ref_sel_e;

   // Run length of zero is treated as a single line.
   function automatic logic [7:0] run_floor8(input logic [7:0] r);
      return (r == 8'd0) ? 8'd1 : r;
   endfunction
endpackage

// File: rtl/vlg_edge.sv
module vlg_edge #(
   parameter int STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise,
   output logic fall
);
   localparam int DEPTH = STAGES + 1;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("vlg_edge: STAGES must be at least 1");
      end
   endgenerate

   logic [DEPTH-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[DEPTH-2:0], din};
   end

   assign rise = pipe[DEPTH-2] & ~pipe[DEPTH-1];
   assign fall = ~pipe[DEPTH-2] & pipe[DEPTH-1];
endmodule

// File: rtl/vlg_down_cnt.sv
module vlg_down_cnt #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic [W-1:0] count,
   output logic         last
);
   generate
      if (W < 1) begin : g_bad_width
         $error("vlg_down_cnt: W must be at least 1");
      end
   endgenerate

   assign last = dec & ~load & (count == W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count <= '0;
      else if (load) count <= load_val;
      else if (dec)  count <= count - W'(1);
   end

   // R3 / R4: callers only count down from a nonzero value
   a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load) |-> (count != '0));
endmodule

// File: rtl/video_line_gate.sv
module video_line_gate
   import vlg_pkg::*;
#(
   parameter int LINE_W = 11,
   parameter int RUN_W  = 8,
   parameter int SYNC_STAGES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csync,
   input  logic              vpulse,
   input  logic              field_idx,
   input  logic              field_mode,
   input  logic              field_inv,
   input  logic [LINE_W-1:0] line_sel,
   input  logic [RUN_W-1:0]  run_len,
   output logic              line_gate,
   output logic              clamp_en
);
   localparam int CW = LINE_W + 1;

   generate
      if (LINE_W < 11) begin : g_bad_line_w
         $error("video_line_gate: LINE_W must reach line 2046");
      end
      if (RUN_W < 1) begin : g_bad_run_w
         $error("video_line_gate: RUN_W must be at least 1");
      end
   endgenerate

   // reference source selection
   ref_sel_e ref_sel;
   logic     ref_raw;
   assign ref_sel = ref_sel_e'(field_mode);
   assign ref_raw = (ref_sel == REF_FIELD) ? (field_idx ^ field_inv) : vpulse;

   logic s_rise, s_fall, r_rise, r_fall;

   vlg_edge #(.STAGES(SYNC_STAGES)) u_sync_edge (
      .clk(clk), .rst_n(rst_n), .din(csync), .rise(s_rise), .fall(s_fall));

   vlg_edge #(.STAGES(SYNC_STAGES)) u_ref_edge (
      .clk(clk), .rst_n(rst_n), .din(ref_raw), .rise(r_rise), .fall(r_fall));

   logic armed_q, gate_q;
   logic sync_tr;
   assign sync_tr = s_rise | s_fall;

   // transition counter
   logic [CW-1:0] tr_cnt, tr_load;
   logic          tr_dec, tr_last;
   assign tr_load = CW'(line_sel) + CW'(2);
   assign tr_dec  = armed_q & ~gate_q & sync_tr & ~r_fall;

   vlg_down_cnt #(.W(CW)) u_tr_cnt (
      .clk(clk), .rst_n(rst_n), .load(r_fall), .load_val(tr_load),
      .dec(tr_dec), .count(tr_cnt), .last(tr_last));

   // remaining-lines counter
   logic [RUN_W-1:0] run_cnt, run_load;
   logic             ln_dec, ln_last;
   assign run_load = (run_len == '0) ? RUN_W'(1) : run_len;
   assign ln_dec   = gate_q & s_rise & ~r_fall;

   vlg_down_cnt #(.W(RUN_W)) u_run_cnt (
      .clk(clk), .rst_n(rst_n), .load(r_fall), .load_val(run_load),
      .dec(ln_dec), .count(run_cnt), .last(ln_last));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         gate_q  <= 1'b0;
      end else if (r_fall) begin
         armed_q <= 1'b1;
         gate_q  <= 1'b0;
      end else begin
         if (tr_last) gate_q <= 1'b1;
         if (ln_last) begin
            gate_q  <= 1'b0;
            armed_q <= 1'b0;
         end
      end
   end

   assign line_gate = gate_q;
   assign clamp_en  = ~gate_q;

   // R2: an idle block keeps its transition count
   a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_q && !r_fall) |=> $stable(tr_cnt));

   // R3: gate only opens from an armed state
   a_r3_open_armed: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_q) |-> $past(armed_q));

   // R3: terminal transition opens the gate
   a_r3_open_on_last: assert property (@(posedge clk) disable iff (!rst_n)
      (tr_last && !r_fall) |=> gate_q);

   // R4: last line boundary closes and disarms
   a_r4_close_disarm: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_q && ln_last) |=> (!gate_q && !armed_q));

   // R4: an open gate always has lines left
   a_r4_lines_left: assert property (@(posedge clk) disable iff (!rst_n)
      gate_q |-> (run_cnt != '0));

   // R6: reference edge reloads and restarts
   a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
      r_fall |=> (armed_q && !gate_q && tr_cnt == $past(tr_load)));

   // R5: a rising reference never starts a count
   a_r5_rise_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
      (r_rise && !armed_q) |=> !armed_q);
endmodule

// File: tb/test_video_line_gate.sv
`timescale 1ns/1ps
module test_video_line_gate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csync = 1'b0;
   logic        vpulse = 1'b0;
   logic        field_idx = 1'b0;
   logic        field_mode = 1'b0;
   logic        field_inv = 1'b0;
   logic [10:0] line_sel = '0;
   logic [7:0]  run_len = '0;
   logic        line_gate, clamp_en;

   video_line_gate i_video_line_gate (
      .clk(clk), .rst_n(rst_n), .csync(csync), .vpulse(vpulse),
      .field_idx(field_idx), .field_mode(field_mode), .field_inv(field_inv),
      .line_sel(line_sel), .run_len(run_len),
      .line_gate(line_gate), .clamp_en(clamp_en));

   always #2 clk = ~clk;

   typedef struct {
      int    t;
      logic  v;
      string tag;
   } exp_t;

   exp_t sb[$];
   int   cyc = 0;
   int   total = 0;
   int   bad = 0;
   bit   mon_en = 0;
   bit   done = 0;
   logic gate_prev = 1'b0;
   exp_t e;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic plain_tr(input int n);
      for (int i = 0; i < n; i++) begin
         csync = ~csync;
         tick(3);
      end
   endtask

   task automatic vref_fall(input bit exp_close, input string tag);
      vpulse = 1'b1;
      tick(3);
      vpulse = 1'b0;
      if (exp_close) sb.push_back(exp_t'{cyc + 2, 1'b0, tag});
      tick(3);
   endtask

   // transitions after a reference edge; done_k already given
   task automatic run_field(input int L, input int R, input string tag, input int done_k);
      int  rn;
      int  k;
      int  rises;
      bit  open;
      rn = (R == 0) ? 1 : R;
      k = done_k;
      rises = 0;
      open = 0;
      forever begin
         k++;
         csync = ~csync;
         if (!open && k == L + 2) begin
            sb.push_back(exp_t'{cyc + 2, 1'b1, tag});
            open = 1;
            tick(3);
         end else if (open && csync) begin
            rises++;
            if (rises == rn) begin
               sb.push_back(exp_t'{cyc + 2, 1'b0, tag});
               tick(3);
               break;
            end
            tick(3);
         end else begin
            tick(3);
         end
      end
      plain_tr(4);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (mon_en && line_gate !== gate_prev) begin
         if (sb.size() == 0) begin
            chk(0, "R2", "unexpected gate change cycle", cyc, -1);
         end else begin
            e = sb.pop_front();
            chk(e.t == cyc && e.v == line_gate, e.tag, "gate edge cycle", cyc, e.t);
         end
         chk(clamp_en === ~line_gate, "R7", "clamp level", int'(clamp_en), int'(~line_gate));
         gate_prev = line_gate;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      tick(5);
      chk(line_gate == 1'b0, "R1", "gate in reset", int'(line_gate), 0);
      chk(clamp_en == 1'b1, "R1", "clamp in reset", int'(clamp_en), 1);
      rst_n = 1'b1;
      tick(3);
      chk(line_gate == 1'b0, "R1", "gate after reset", int'(line_gate), 0);
      mon_en = 1;

      // R2: no reference yet
      line_sel = 11'd1; run_len = 8'd1;
      plain_tr(6);
      chk(line_gate == 1'b0, "R2", "gate without reference", int'(line_gate), 0);

      // R3: line 14 opens on the 16th transition
      line_sel = 11'd14; run_len = 8'd1;
      vref_fall(0, "R3");
      run_field(14, 1, "R3", 0);

      // R4: run length zero acts as one
      line_sel = 11'd0; run_len = 8'd0;
      vref_fall(0, "R4");
      run_field(0, 0, "R4", 0);

      // R4: contiguous run of four lines, then no reopen
      line_sel = 11'd3; run_len = 8'd4;
      vref_fall(0, "R4");
      run_field(3, 4, "R4", 0);
      plain_tr(12);
      chk(line_gate == 1'b0, "R4", "no reopen after run", int'(line_gate), 0);

      // R5: field index ignored in vertical mode
      line_sel = 11'd3; run_len = 8'd1;
      field_idx = 1'b1; tick(3);
      field_idx = 1'b0; tick(3);
      plain_tr(6);
      chk(line_gate == 1'b0, "R5", "field index ignored", int'(line_gate), 0);

      // R6: reload while counting
      line_sel = 11'd30; run_len = 8'd1;
      vref_fall(0, "R6");
      plain_tr(10);
      line_sel = 11'd2; run_len = 8'd2;
      vref_fall(0, "R6");
      run_field(2, 2, "R6", 0);

      // R6: reload while the gate is open
      line_sel = 11'd1; run_len = 8'd5;
      vref_fall(0, "R6");
      for (int i = 1; i <= 4; i++) begin
         csync = ~csync;
         if (i == 3) sb.push_back(exp_t'{cyc + 2, 1'b1, "R6"});
         tick(3);
      end
      chk(line_gate == 1'b1, "R6", "gate open before reload", int'(line_gate), 1);
      line_sel = 11'd5; run_len = 8'd1;
      vref_fall(1, "R6");
      run_field(5, 1, "R6", 0);

      // R5: field mode, vpulse ignored mid-count
      field_mode = 1'b1; tick(3);
      line_sel = 11'd4; run_len = 8'd2;
      field_idx = 1'b1; tick(3);
      field_idx = 1'b0; tick(3);
      plain_tr(2);
      vpulse = 1'b1; tick(3);
      vpulse = 1'b0; tick(3);
      run_field(4, 2, "R5", 2);

      // R5: inverted index, rising field_idx starts
      field_inv = 1'b1; tick(3);
      line_sel = 11'd6; run_len = 8'd1;
      field_idx = 1'b1; tick(3);
      run_field(6, 1, "R5", 0);

      // R8: highest line
      field_idx = 1'b0; tick(3);
      line_sel = 11'd2046; run_len = 8'd2;
      field_idx = 1'b1; tick(3);
      run_field(2046, 2, "R8", 0);

      tick(10);
      chk(sb.size() == 0, "R4", "pending expected gate edges", sb.size(), 0);
      chk(clamp_en == ~line_gate, "R7", "final clamp level", int'(clamp_en), int'(~line_gate));
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule